// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM. Its array is small and parameterised: 256 words of four byte lanes by default, each lane 8 or 9 bits wide. With 9-bit lanes, the top bit of each lane is a parity bit that is stored and masked along with its lane. Every command passes through two register stages. A read presents its word on the data bus after the second enabled clock edge. A write takes its data from the bus at that same second edge. Because reads and writes have the same latency, they can follow each other in any order with no idle bus cycles.

Each captured write is held in a one-entry buffer. The buffer is copied into the array when the next write retires. A read that finds its address in the buffer combines the buffered lanes with the array word, so read-after-write data is correct without a stall. A load cycle starts a read, a write or a deselect, according to three chip selects and a direction input. Continuation cycles keep the same operation and step a two-bit burst counter, in either linear or interleaved order. A stall input freezes the whole pipeline. An asynchronous output enable gates only the bus drivers.

Top module: `lw_pipe_sram`

## Requirements
- R1: A read command accepted at an enabled edge puts its word on `rd_data`, with `rd_data_oe` high, after the second enabled edge that follows. The word stays there until the next enabled edge.
- R2: A write command, its address and its lane enables are registered at an enabled edge. The write data on `wr_data` is sampled at the second enabled edge after it.
- R3: A load cycle (`burst_cont`=0) selects the device only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. When selected, `is_read`=1 starts a read and `is_read`=0 starts a write. Any other select combination starts a deselect, which neither writes nor reads.
- R4: `lane_wr_n[i]` is active low and controls bits [i*LANE_W +: LANE_W], including the parity bit when LANE_W is 9. It is sampled on every write beat. Lanes that are not enabled keep their stored contents.
- R5: While `stall` is 1, no stage, counter, buffer or output register changes. The inputs are ignored, and every pending operation resumes unchanged when `stall` returns to 0.
- R6: `out_en_n` acts without a clock and only gates `rd_data_oe`. It changes no stored data and no pipeline timing.
- R7: After a deselect or a write, `rd_data_oe` is low following the second enabled edge. Operations already in flight still complete.
- R8: On a continuation cycle (`burst_cont`=1), `addr`, the chip selects and `is_read` are ignored. The previous operation repeats at the next burst address. After a deselect, the device stays deselected.
- R9: Burst addresses keep the upper address bits of the load address. The low two bits are (start + n) mod 4 when `burst_linear`=1, and start XOR n when `burst_linear`=0, where n counts the beats since the load (mod 4).
- R10: A read issued at any distance after a write to the same address returns the newly written lanes merged with the older lanes, with no idle cycles in between.
- R11: While `rst_n` is low, the pipeline is emptied, the burst state becomes a deselect, the write buffer is cleared and `rd_data_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | 1 freezes the whole device for this edge |
| addr | input | AW | Word address, used on load cycles |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| is_read | input | 1 | 1 read, 0 write, used on load cycles |
| burst_cont | input | 1 | 1 continue burst, 0 load a new command |
| burst_linear | input | 1 | 1 linear burst order, 0 interleaved |
| lane_wr_n | input | LANES | Active-low write enable per byte lane |
| out_en_n | input | 1 | Asynchronous active-low output drive enable |
| wr_data | input | LANES*LANE_W | Write data, sampled two enabled edges after its command |
| rd_data | output | LANES*LANE_W | Read data register |
| rd_data_oe | output | 1 | High when the bus is driven with `rd_data` |

## Verification
Every result of this block falls due at the second enabled edge after its command: read data and the bus enable appear then, and write data is taken then. Stalled edges do not count. The bench drives its inputs on the falling edge. It keeps a queue of commands that advances only on enabled cycles, and it applies writes to its reference memory at the moment a write leaves that queue. At the next falling edge, it compares `rd_data_oe` and `rd_data` with the values due after the edge just passed. The enable check uses the output-enable level that held during that cycle.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  localparam int BEAT_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // all three selects must be active at once
  function automatic logic chip_selected(input logic a_n, input logic b, input logic c_n);
    return !a_n && b && !c_n;
  endfunction

  // low address bits of burst beat n from the start offset
  function automatic logic [BEAT_W-1:0] beat_offset(input logic [BEAT_W-1:0] start,
                                                    input logic [BEAT_W-1:0] n,
                                                    input logic linear);
    return linear ? (start + n) : (start ^ n);
  endfunction

  function automatic op_e load_op(input logic sel, input logic rd);
    if (!sel) return OP_IDLE;
    return rd ? OP_RD : OP_WR;
  endfunction

endpackage

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DW     = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] wmask,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (wmask[l]) mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/lw_sram_cmd.sv
module lw_sram_cmd
  import lw_sram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  input  logic             chip_sel,
  input  logic             is_read,
  input  logic             burst_cont,
  input  logic             burst_linear,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] lane_wr_n,
  output op_e              s1_op,
  output logic [AW-1:0]    s1_addr,
  output logic [LANES-1:0] s1_lanes
);

  localparam int BB = BEAT_W;

  logic [AW-1:0] base_q, nxt_base;
  logic [BB-1:0] cnt_q, nxt_cnt;
  logic [AW-1:0] nxt_addr;
  op_e           nxt_op;

  always_comb begin
    if (!burst_cont) begin
      nxt_op   = load_op(chip_sel, is_read);
      nxt_addr = addr;
      nxt_base = addr;
      nxt_cnt  = '0;
    end else begin
      nxt_op   = s1_op;
      nxt_base = base_q;
      nxt_cnt  = cnt_q + 1'b1;
      nxt_addr = {base_q[AW-1:BB], beat_offset(base_q[BB-1:0], nxt_cnt, burst_linear)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op    <= OP_IDLE;
      s1_addr  <= '0;
      s1_lanes <= '0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else if (adv_en) begin
      s1_op    <= nxt_op;
      s1_addr  <= nxt_addr;
      s1_lanes <= ~lane_wr_n;
      base_q   <= nxt_base;
      cnt_q    <= nxt_cnt;
    end
  end

endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf
  import lw_sram_pkg::*;
#(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DW     = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  input  op_e              s2_op,
  input  logic [AW-1:0]    s2_addr,
  input  logic [LANES-1:0] s2_lanes,
  input  logic [DW-1:0]    wr_data,
  input  logic [DW-1:0]    arr_word,
  output logic             arr_we,
  output logic [AW-1:0]    arr_waddr,
  output logic [DW-1:0]    arr_wdata,
  output logic [LANES-1:0] arr_wmask,
  output logic [DW-1:0]    rd_word
);

  logic             buf_vld;
  logic [AW-1:0]    buf_addr;
  logic [DW-1:0]    buf_data;
  logic [LANES-1:0] buf_mask;
  logic             capture;
  logic             fwd_hit;

  assign capture   = adv_en && (s2_op == OP_WR);
  assign arr_we    = capture && buf_vld;
  assign arr_waddr = buf_addr;
  assign arr_wdata = buf_data;
  assign arr_wmask = buf_mask;
  assign fwd_hit   = buf_vld && (buf_addr == s2_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_vld  <= 1'b0;
      buf_addr <= '0;
      buf_data <= '0;
      buf_mask <= '0;
    end else if (capture) begin
      buf_vld  <= 1'b1;
      buf_addr <= s2_addr;
      buf_data <= wr_data;
      buf_mask <= s2_lanes;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign rd_word[l*LANE_W +: LANE_W] = (fwd_hit && buf_mask[l]) ?
        buf_data[l*LANE_W +: LANE_W] : arr_word[l*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/lw_sram_dout.sv
module lw_sram_dout
  import lw_sram_pkg::*;
#(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_en,
  input  op_e           s2_op,
  input  logic [DW-1:0] rd_word,
  output logic          rd_vld,
  output logic [DW-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else if (adv_en) begin
      rd_vld <= (s2_op == OP_RD);
      if (s2_op == OP_RD) rd_data <= rd_word;
    end
  end

endmodule

// File: rtl/lw_pipe_sram.sv
module lw_pipe_sram
  import lw_sram_pkg::*;
#(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stall,
  input  logic [AW-1:0]           addr,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    is_read,
  input  logic                    burst_cont,
  input  logic                    burst_linear,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_data_oe
);

  localparam int DW = LANES * LANE_W;

  logic             adv_en;
  logic             chip_sel;
  op_e              s1_op, s2_op;
  logic [AW-1:0]    s1_addr, s2_addr;
  logic [LANES-1:0] s1_lanes, s2_lanes;
  logic             arr_we;
  logic [AW-1:0]    arr_waddr;
  logic [DW-1:0]    arr_wdata, arr_word, rd_word;
  logic [LANES-1:0] arr_wmask;
  logic             rd_vld;

  assign adv_en   = !stall;
  assign chip_sel = chip_selected(sel_a_n, sel_b, sel_c_n);

  lw_sram_cmd #(.AW(AW), .LANES(LANES)) u_cmd (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .chip_sel(chip_sel),
    .is_read(is_read), .burst_cont(burst_cont), .burst_linear(burst_linear),
    .addr(addr), .lane_wr_n(lane_wr_n),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_lanes(s1_lanes)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_op    <= OP_IDLE;
      s2_addr  <= '0;
      s2_lanes <= '0;
    end else if (adv_en) begin
      s2_op    <= s1_op;
      s2_addr  <= s1_addr;
      s2_lanes <= s1_lanes;
    end
  end

  lw_sram_wbuf #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W), .DW(DW)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .s2_op(s2_op), .s2_addr(s2_addr),
    .s2_lanes(s2_lanes), .wr_data(wr_data), .arr_word(arr_word),
    .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
    .arr_wmask(arr_wmask), .rd_word(rd_word)
  );

  lw_sram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W), .DW(DW)) u_array (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .wmask(arr_wmask), .raddr(s2_addr), .rdata(arr_word)
  );

  lw_sram_dout #(.DW(DW)) u_dout (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .s2_op(s2_op),
    .rd_word(rd_word), .rd_vld(rd_vld), .rd_data(rd_data)
  );

  assign rd_data_oe = rd_vld && !out_en_n;

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk
  import lw_sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic          burst_cont,
  input logic          out_en_n,
  input logic          chip_sel,
  input logic          rd_data_oe,
  input logic          rd_vld,
  input logic [DW-1:0] rd_data,
  input op_e           s1_op,
  input logic [AW-1:0] s1_addr,
  input op_e           s2_op,
  input logic          arr_we
);

  localparam int BB = BEAT_W;

  // R11
  reset_empty_chk: assert property (@(posedge clk)
    !rst_n |=> (!rd_vld && s1_op == OP_IDLE && s2_op == OP_IDLE));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(rd_data) && $stable(rd_vld) && $stable(s1_op) && $stable(s1_addr)
               && $stable(s2_op)));

  // R1
  read_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && s2_op == OP_RD) |=> (rd_data_oe == !out_en_n));

  // R7
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && s2_op != OP_RD) |=> !rd_data_oe);

  // R6
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_oe |-> !out_en_n);

  // R3
  no_sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !burst_cont && !chip_sel) |=> (s1_op == OP_IDLE));

  // R8
  burst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && burst_cont) |=> (s1_op == $past(s1_op)
                                && s1_addr[AW-1:BB] == $past(s1_addr[AW-1:BB])));

  // R2
  wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (!stall && s2_op == OP_WR));

endmodule

bind lw_pipe_sram lw_sram_chk #(.AW(AW), .DW(LANES*LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .burst_cont(burst_cont),
  .out_en_n(out_en_n), .chip_sel(chip_sel), .rd_data_oe(rd_data_oe),
  .rd_vld(rd_vld), .rd_data(rd_data), .s1_op(s1_op), .s1_addr(s1_addr),
  .s2_op(s2_op), .arr_we(arr_we)
);

// File: tb/tb_lw_pipe_sram.sv
module tb_lw_pipe_sram;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 8;
  localparam int NL    = 4;
  localparam int LW    = 9;
  localparam int DW    = NL * LW;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] SEL = 3'b010;  // {sel_c_n, sel_b, sel_a_n}

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic          is_read = 1'b1;
  logic          burst_cont = 1'b0;
  logic          burst_linear = 1'b1;
  logic [NL-1:0] lane_wr_n = '1;
  logic          out_en_n = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_data_oe;

  lw_pipe_sram #(.AW(AW), .LANES(NL), .LANE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .addr(addr), .sel_a_n(sel_a_n),
    .sel_b(sel_b), .sel_c_n(sel_c_n), .is_read(is_read), .burst_cont(burst_cont),
    .burst_linear(burst_linear), .lane_wr_n(lane_wr_n), .out_en_n(out_en_n),
    .wr_data(wr_data), .rd_data(rd_data), .rd_data_oe(rd_data_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int            kind;  // 0 none, 1 read, 2 write
    int            adr;
    logic [NL-1:0] en;
  } pend_t;

  logic [DW-1:0] ref_mem [DEPTH];
  pend_t         pq[$];
  int            b_kind, b_base, b_cnt;
  bit            exp_vld;
  logic [DW-1:0] exp_data;
  int            n_cmp = 0, n_bad = 0;
  string         tag = "R11 reset";
  logic          g_oe_n = 1'b0, g_lin = 1'b1;

  function automatic logic [DW-1:0] rnd();
    return DW'({$urandom(), $urandom()});
  endfunction

  task automatic compare();
    logic exp_oe;
    exp_oe = exp_vld && !out_en_n;
    n_cmp++;
    if (rd_data_oe !== exp_oe) begin
      n_bad++;
      $display("FAIL %s: rd_data_oe actual=%b expected=%b at %0t", tag, rd_data_oe, exp_oe, $time);
    end else if (exp_oe && rd_data !== exp_data) begin
      n_bad++;
      $display("FAIL %s: rd_data actual=%h expected=%h at %0t", tag, rd_data, exp_data, $time);
    end
  endtask

  task automatic model(input logic bc, input logic rd, input logic [AW-1:0] ad,
                       input logic [2:0] ce, input logic [NL-1:0] bw, input logic [DW-1:0] dat);
    pend_t nc, r;
    int cur, lo;
    if (!bc) begin
      if (ce == SEL) b_kind = rd ? 1 : 2;
      else b_kind = 0;
      b_base = int'(ad);
      b_cnt  = 0;
      cur    = int'(ad);
    end else begin
      b_cnt = (b_cnt + 1) % 4;
      if (g_lin) lo = ((b_base % 4) + b_cnt) % 4;
      else lo = (b_base % 4) ^ b_cnt;
      cur = (b_base / 4) * 4 + lo;
    end
    nc.kind = b_kind;
    nc.adr  = cur;
    nc.en   = ~bw;
    pq.push_back(nc);
    r = pq.pop_front();
    exp_vld = (r.kind == 1);
    if (r.kind == 2) begin
      for (int l = 0; l < NL; l++)
        if (r.en[l]) ref_mem[r.adr][l*LW +: LW] = dat[l*LW +: LW];
    end
    if (r.kind == 1) exp_data = ref_mem[r.adr];
  endtask

  task automatic step(input logic st, input logic bc, input logic rd, input logic [AW-1:0] ad,
                      input logic [2:0] ce, input logic [NL-1:0] bw, input logic [DW-1:0] dat);
    @(negedge clk);
    compare();
    stall        = st;
    burst_cont   = bc;
    is_read      = rd;
    addr         = ad;
    {sel_c_n, sel_b, sel_a_n} = ce;
    lane_wr_n    = bw;
    wr_data      = dat;
    out_en_n     = g_oe_n;
    burst_linear = g_lin;
    if (!st) model(bc, rd, ad, ce, bw, dat);
  endtask

  task automatic wr(input int a, input logic [NL-1:0] bw);
    step(1'b0, 1'b0, 1'b0, AW'(a), SEL, bw, rnd());
  endtask

  task automatic rdc(input int a);
    step(1'b0, 1'b0, 1'b1, AW'(a), SEL, '1, rnd());
  endtask

  task automatic cont(input logic [NL-1:0] bw);
    // junk address, selects and direction must be ignored (R8)
    step(1'b0, 1'b1, $urandom_range(0, 1) == 1, AW'($urandom_range(0, DEPTH - 1)),
         3'($urandom_range(0, 7)), bw, rnd());
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b1, '0, 3'b111, '1, rnd());
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    pq.push_back('{0, 0, '0});
    pq.push_back('{0, 0, '0});
    b_kind = 0; b_base = 0; b_cnt = 0;
    exp_vld = 1'b0; exp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: outputs quiet right after reset
    tag = "R11 reset";
    idle(2);

    // R2: fill the array with four-beat full-word write bursts
    tag = "R2 write fill";
    g_lin = 1'b1;
    for (int a = 0; a < DEPTH; a += 4) begin
      wr(a, '0);
      repeat (3) cont('0);
    end
    idle(3);

    // R10: reads directly behind writes to the same word
    tag = "R10 read-after-write";
    wr(3, '0); rdc(3); wr(3, 4'b1100); rdc(3); rdc(3);
    wr(7, 4'b0110); wr(7, 4'b1001); rdc(7); wr(3, '0); rdc(7); rdc(3);
    idle(3);

    // R1: back-to-back reads of several words
    tag = "R1 read latency";
    rdc(0); rdc(255); rdc(3); rdc(128); idle(3);

    // R4: lane masks, parity bit travels with its lane
    tag = "R4 lane mask";
    wr(9, 4'b1010); idle(2); rdc(9); wr(9, 4'b0101); wr(9, 4'b1111); rdc(9); idle(3);
    wr(10, 4'b1110); cont(4'b0111); cont(4'b1011); cont(4'b1101); rdc(10); rdc(11);
    idle(3);

    // R9: interleaved and linear burst orders
    tag = "R9 burst order";
    g_lin = 1'b0;
    rdc(6); repeat (3) cont('1);
    step(1'b0, 1'b0, 1'b0, 13, SEL, '0, rnd()); repeat (3) cont('0);
    g_lin = 1'b1;
    rdc(6); repeat (3) cont('1);
    rdc(13); repeat (5) cont('1);
    idle(3);

    // R8: continuation after a deselect stays deselected
    tag = "R8 continuation";
    step(1'b0, 1'b0, 1'b0, 20, 3'b111, '0, rnd());
    repeat (4) cont('0);
    rdc(20); rdc(21); idle(3);

    // R3: each inactive select blocks the command
    tag = "R3 select";
    step(1'b0, 1'b0, 1'b0, 30, 3'b011, '0, rnd());
    step(1'b0, 1'b0, 1'b0, 30, 3'b000, '0, rnd());
    step(1'b0, 1'b0, 1'b0, 30, 3'b110, '0, rnd());
    step(1'b0, 1'b0, 1'b1, 30, 3'b011, '1, rnd());
    rdc(30); idle(3);

    // R7: deselect releases the bus two edges later
    tag = "R7 deselect";
    rdc(1); rdc(2); idle(1); rdc(4); wr(5, '0); idle(3);

    // R5: stalls hold pending reads and writes
    tag = "R5 stall";
    wr(40, '0);
    repeat (3) step(1'b1, 1'b0, 1'b1, 41, SEL, '0, rnd());
    rdc(40);
    repeat (2) step(1'b1, 1'b0, 1'b0, 42, SEL, '0, rnd());
    idle(1);
    repeat (3) step(1'b1, 1'b1, 1'b0, 43, SEL, '0, rnd());
    idle(3);

    // R6: output enable toggled during a read burst
    tag = "R6 output enable";
    rdc(40); g_oe_n = 1'b1; cont('1); g_oe_n = 1'b0; cont('1); g_oe_n = 1'b1; cont('1);
    g_oe_n = 1'b0; idle(1); g_oe_n = 1'b1; idle(1); g_oe_n = 1'b0; rdc(40); idle(3);

    // R1/R10 mixed random traffic on a small address window
    tag = "R1/R10 random mix";
    for (int i = 0; i < 4000; i++) begin
      logic st, bc, rd;
      logic [2:0] ce;
      if (i % 200 == 0) g_lin = 1'($urandom_range(0, 1));
      g_oe_n = ($urandom_range(0, 9) == 0);
      st = ($urandom_range(0, 9) == 0);
      bc = ($urandom_range(0, 9) < 3);
      rd = 1'($urandom_range(0, 1));
      ce = ($urandom_range(0, 9) < 8) ? SEL : 3'($urandom_range(0, 7));
      step(st, bc, rd, AW'($urandom_range(0, 15)), ce, NL'($urandom_range(0, 15)), rnd());
    end
    g_oe_n = 1'b0;
    idle(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule